// File: doc/BRIEF.md
# Filtered Quadrature Position Counter with Capture

This block turns the two phase signals of one incremental encoder into a signed 32-bit position. Every input first passes a two-flop synchroniser and then a dwell filter. A new level is taken only after it has stayed unchanged for a set number of clock cycles, so short noise spikes never reach the counter. Each accepted change of the phase pair moves the count one step up or down. A change in which both phases flip at once cannot be decoded. It leaves the count alone and raises a sticky error flag.

The block also records the position at a reference event, using a mode input to pick the source. In index mode, the event occurs when the filtered index line is low and the phase pair settles into the both-low state by a legal step, which is the later of the two falling phase edges. In home mode, the event is the filtered falling edge of the home line, whatever the phases are doing. After an event the capture register stays frozen until the host strobes a rearm. A one-cycle pulse marks each capture for interrupt logic.

Top module: `quad_capture_counter`

## Requirements
- R1: After reset, position, cap_value and jump_err read 0, and cap_valid and cap_pulse are low.
- R2: Write the phase pair as {enc_a, enc_b}. The forward sequence is 00, 10, 11, 01, 00 (A leads B). Each accepted forward step adds 1 to position and each accepted reverse step subtracts 1, wrapping modulo 2^32, so one reverse step from 0 gives 32'hFFFFFFFF.
- R3: A new level on enc_a/enc_b, idx_n or home_n takes effect only after it has been held for DWELL consecutive synchronised cycles (default 20). A pulse shorter than that changes nothing.
- R4: An accepted change in which both phases differ from the previous accepted pair leaves position unchanged and sets jump_err. jump_err then stays set until reset.
- R5: The first phase pair accepted after reset becomes the reference state and does not change position.
- R6: With cap_sel = 0, a capture happens when the filtered idx_n is low and the accepted pair steps legally into 00 from 10 or 01. cap_value then takes the position that includes that step. If idx_n is high, no capture happens.
- R7: With cap_sel = 1, a capture happens on the filtered falling edge of home_n, and index activity is ignored. With cap_sel = 0, home_n activity is ignored.
- R8: While cap_valid is high, cap_value and cap_valid hold through any further event. A rearm strobe clears cap_valid, and the next event captures again.
- R9: cap_pulse is high for exactly one cycle per capture, in the same cycle that cap_valid rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Raw encoder phase A |
| enc_b | input | 1 | Raw encoder phase B |
| idx_n | input | 1 | Raw index, active low |
| home_n | input | 1 | Raw home switch, active low |
| cap_sel | input | 1 | Capture source: 0 index, 1 home |
| rearm | input | 1 | One-cycle strobe that frees the capture register |
| position | output | 32 | Signed position count |
| cap_value | output | 32 | Captured position |
| cap_valid | output | 1 | Capture register holds an unread value |
| cap_pulse | output | 1 | One-cycle capture event |
| jump_err | output | 1 | Sticky illegal double-phase change flag |

## Verification
In index mode, the accepted phase step that triggers a capture also updates the counter in the same cycle. The captured value must therefore already include that step. The bench drives this case by holding the index line low while walking the phases forward into the both-low state. It judges the result by comparing cap_value with its own model position after the step, not the value before it. Each capture is also counted through the event pulse, so a capture that is missing or repeated during the freeze is detected.

// File: rtl/quad_capture_counter.sv
module quad_capture_counter #(
  parameter int CNT_W = 32,
  parameter int DWELL = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             idx_n,
  input  logic             home_n,
  input  logic             cap_sel,
  input  logic             rearm,
  output logic [CNT_W-1:0] position,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_valid,
  output logic             cap_pulse,
  output logic             jump_err
);
  localparam int DW = $clog2(DWELL + 1);
  localparam logic [DW-1:0] FULL = DW'(DWELL - 1);

  logic [1:0] ab_s1, ab_s2, ab_c, ab_f;
  logic [DW-1:0] ab_n;
  logic primed;
  logic [1:0] lv_s1, lv_s2, lv_c, lv_f, lv_take, lv_fall;
  logic [DW-1:0] lv_n [2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ab_s1 <= 2'b11; ab_s2 <= 2'b11;
      lv_s1 <= 2'b11; lv_s2 <= 2'b11;
    end else begin
      ab_s1 <= {enc_a, enc_b}; ab_s2 <= ab_s1;
      lv_s1 <= {home_n, idx_n}; lv_s2 <= lv_s1;
    end

  logic ab_take;
  assign ab_take = (ab_n == FULL) && (ab_s2 == ab_c) && (!primed || ab_c != ab_f);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ab_c <= 2'b11; ab_f <= 2'b11; ab_n <= '0; primed <= 1'b0;
    end else begin
      ab_c <= ab_s2;
      if (ab_s2 != ab_c) ab_n <= '0;
      else if (ab_n != FULL) ab_n <= ab_n + 1'b1;
      if (ab_take) begin
        ab_f <= ab_c;
        primed <= 1'b1;
      end
    end

  always_comb
    for (int k = 0; k < 2; k++) begin
      lv_take[k] = (lv_n[k] == FULL) && (lv_s2[k] == lv_c[k]) && (lv_c[k] != lv_f[k]);
      lv_fall[k] = lv_take[k] && !lv_c[k];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lv_c <= 2'b11; lv_f <= 2'b11;
      for (int k = 0; k < 2; k++) lv_n[k] <= '0;
    end else begin
      lv_c <= lv_s2;
      for (int k = 0; k < 2; k++) begin
        if (lv_s2[k] != lv_c[k]) lv_n[k] <= '0;
        else if (lv_n[k] != FULL) lv_n[k] <= lv_n[k] + 1'b1;
        if (lv_take[k]) lv_f[k] <= lv_c[k];
      end
    end

  logic [1:0] ph_old, ph_new, ph_d;
  logic step_fwd, step_rev, step_jump;
  logic [CNT_W-1:0] pos_nxt;

  assign ph_old    = {ab_f[0], ab_f[1] ^ ab_f[0]};
  assign ph_new    = {ab_c[0], ab_c[1] ^ ab_c[0]};
  assign ph_d      = ph_new - ph_old;
  assign step_fwd  = ab_take && primed && ph_d == 2'd1;
  assign step_rev  = ab_take && primed && ph_d == 2'd3;
  assign step_jump = ab_take && primed && ph_d == 2'd2;
  assign pos_nxt   = position + {{(CNT_W-1){step_rev}}, step_fwd | step_rev};

  logic idx_ev, home_ev, cap_take;
  assign idx_ev   = !cap_sel && (step_fwd || step_rev) && ab_c == 2'b00 && !lv_f[0];
  assign home_ev  = cap_sel && lv_fall[1];
  assign cap_take = (idx_ev || home_ev) && (!cap_valid || rearm);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      position  <= '0;
      jump_err  <= 1'b0;
      cap_value <= '0;
      cap_valid <= 1'b0;
      cap_pulse <= 1'b0;
    end else begin
      position  <= pos_nxt;
      if (step_jump) jump_err <= 1'b1;
      cap_pulse <= cap_take;
      if (cap_take) begin
        cap_value <= pos_nxt;
        cap_valid <= 1'b1;
      end else if (rearm) cap_valid <= 1'b0;
    end

  a_r2_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(position) |-> (position - $past(position) == 1 || $past(position) - position == 1));

  a_r4_jump_holds: assert property (@(posedge clk) disable iff (!rst_n)
    step_jump |=> ($stable(position) && jump_err));

  a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    jump_err |=> jump_err);

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !rearm) |=> (cap_valid && $stable(cap_value)));

  a_r9_pulse_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cap_pulse |-> cap_valid);

  a_r6_index_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_sel && lv_f[0] && !cap_valid) |=> !cap_pulse);
endmodule

// File: tb/sim_quad_capture_counter.sv
module sim_quad_capture_counter;
  logic clk = 0, rst_n = 0;
  logic enc_a = 1, enc_b = 1, idx_n = 1, home_n = 1, cap_sel = 0, rearm = 0;
  logic [31:0] position, cap_value;
  logic cap_valid, cap_pulse, jump_err;
  int checks = 0, errors = 0, pulses = 0;
  logic [31:0] exp_pos = 0;
  bit done = 0;

  always #4 clk = ~clk;

  quad_capture_counter u0 (.clk, .rst_n, .enc_a, .enc_b, .idx_n, .home_n, .cap_sel,
    .rearm, .position, .cap_value, .cap_valid, .cap_pulse, .jump_err);

  always @(negedge clk) if (cap_pulse) pulses++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle(int n = 40);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_ab(logic a, logic b);
    enc_a = a; enc_b = b;
    settle();
  endtask

  task automatic step_fwd();
    case ({enc_a, enc_b})
      2'b00: set_ab(1, 0);
      2'b10: set_ab(1, 1);
      2'b11: set_ab(0, 1);
      default: set_ab(0, 0);
    endcase
    exp_pos++;
  endtask

  task automatic step_rev();
    case ({enc_a, enc_b})
      2'b00: set_ab(0, 1);
      2'b01: set_ab(1, 1);
      2'b11: set_ab(1, 0);
      default: set_ab(0, 0);
    endcase
    exp_pos--;
  endtask

  task automatic do_rearm();
    @(negedge clk); rearm = 1;
    @(negedge clk); rearm = 0;
  endtask

  task automatic t_reset();
    settle(5);
    chk("R1 position", position, 0);
    chk("R1 cap_value", cap_value, 0);
    chk("R1 flags", {29'd0, cap_valid, cap_pulse, jump_err}, 0);
    rst_n = 1;
    settle();
    chk("R5 first state no count", position, 0);
  endtask

  task automatic t_forward();
    for (int i = 0; i < 4; i++) begin
      step_fwd();
      chk("R2 forward step", position, exp_pos);
    end
  endtask

  task automatic t_reverse();
    for (int i = 0; i < 5; i++) begin
      step_rev();
      chk("R2 reverse step", position, exp_pos);
    end
    chk("R2 wrap below zero", position, 32'hFFFFFFFF);
    step_fwd();
    chk("R2 back to zero", position, 0);
  endtask

  task automatic t_glitch();
    logic a0, b0;
    a0 = enc_a; b0 = enc_b;
    enc_a = ~a0;
    repeat (5) @(posedge clk);
    enc_a = a0;
    settle();
    chk("R3 short phase pulse ignored", position, exp_pos);
    enc_a = b0 ^ a0 ? a0 : a0;
  endtask

  task automatic t_jump();
    set_ab(~enc_a, ~enc_b);
    chk("R4 jump no count", position, exp_pos);
    chk("R4 jump flag", {31'd0, jump_err}, 1);
    step_fwd();
    chk("R4 count after jump", position, exp_pos);
    chk("R4 flag sticky", {31'd0, jump_err}, 1);
  endtask

  task automatic t_index();
    int p0;
    cap_sel = 0;
    while ({enc_a, enc_b} != 2'b11) step_fwd();
    idx_n = 0; settle();
    p0 = pulses;
    step_fwd();
    chk("R6 no capture before 00", {31'd0, cap_valid}, 0);
    step_fwd();
    chk("R6 index capture valid", {31'd0, cap_valid}, 1);
    chk("R6 captured value includes step", cap_value, exp_pos);
    chk("R9 one pulse", pulses - p0, 1);
    for (int i = 0; i < 4; i++) step_fwd();
    chk("R8 frozen value", cap_value, exp_pos - 4);
    chk("R8 no extra pulse", pulses - p0, 1);
    idx_n = 1; settle();
    do_rearm(); settle(2);
    chk("R8 rearm clears", {31'd0, cap_valid}, 0);
    for (int i = 0; i < 4; i++) step_fwd();
    chk("R6 index high no capture", {31'd0, cap_valid}, 0);
    idx_n = 0; settle();
    for (int i = 0; i < 4; i++) step_rev();
    chk("R8 recapture after rearm", cap_value, exp_pos);
    chk("R9 pulse count", pulses - p0, 2);
    home_n = 0; settle(); home_n = 1; settle();
    chk("R7 home ignored in index mode", pulses - p0, 2);
    idx_n = 1; settle();
  endtask

  task automatic t_home();
    int p0;
    cap_sel = 1;
    do_rearm(); settle(2);
    p0 = pulses;
    idx_n = 0; settle();
    for (int i = 0; i < 4; i++) step_fwd();
    chk("R7 index ignored in home mode", {31'd0, cap_valid}, 0);
    idx_n = 1; settle();
    home_n = 0;
    repeat (5) @(posedge clk);
    home_n = 1; settle();
    chk("R3 short home pulse ignored", {31'd0, cap_valid}, 0);
    step_fwd();
    home_n = 0; settle();
    chk("R7 home capture value", cap_value, exp_pos);
    chk("R9 home pulse", pulses - p0, 1);
    home_n = 1; settle();
  endtask

  initial begin
    t_reset();
    t_forward();
    t_reverse();
    t_glitch();
    t_index();
    t_home();
    t_jump();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule